// File: doc/BRIEF.md
# Byte-lane page-mode DRAM controller

This block connects a simple synchronous host to a 1M x 16 asynchronous DRAM. The host offers one request at a time: a 20-bit word address, a read or write flag, 16 bits of write data and two byte enables. The controller accepts it with a ready handshake. It splits the address into a row and a column on a shared 10-bit bus and sequences the row strobe, the two column strobes, write enable and output enable. Read data comes back with a one-cycle valid pulse.

Every timing minimum is a parameter in nanoseconds. Each one is converted to clock cycles and rounded up. The controller starts from reset with a settling pause and eight refresh cycles. After that it raises the refresh demand at a fixed interval and serves it with CAS-before-RAS cycles. Refresh wins over the next host request. If a request arrives while its row is still open, the controller issues a new column cycle and does not reopen the row.

Top module: `dram_page_ctrl`

## Requirements
- R1: After reset, `req_ready` stays low and no strobe falls until the initial pause has elapsed. Exactly eight refresh cycles then run before `req_ready` first rises.
- R2: The row address is `req_addr[19:10]`, present when RAS falls. The column address is `req_addr[9:0]`, present when a column strobe falls.
- R3: Byte enable bit 0 selects the lower strobe, which covers data bits 7:0. Bit 1 selects the upper strobe, which covers bits 15:8. A write to one lane leaves the other lane of that word unchanged.
- R4: On a write, WE is low in the cycle before the column strobes fall and stays low while they fall, and the write data is on the bus. The controller drives the bus only during write cycles, and never while OE is low.
- R5: On a read, OE is low during the column access. The sampled word appears on `rsp_rdata` with `rsp_valid` high for one cycle. A lane whose enable is clear reads as zero.
- R6: A refresh lowers both column strobes at least one cycle before RAS falls, with WE and OE high, and drives no row address.
- R7: Once start-up is done, a refresh becomes due every `T_REF_NS`. A due refresh waits only for the access in progress and runs before the next host request. Up to `PEND_MAX` due refreshes are counted.
- R8: When a request for the row that is already open arrives at the end of a column cycle, RAS stays low and only a new column access runs (page mode).
- R9: A request for another row closes the open row. RAS then stays high for at least the precharge time before it falls again, and successive RAS falls are at least the cycle time apart.
- R10: RAS fall to read sampling is at least the RAS access time. CAS fall to sampling is at least the CAS access time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address: row in 19:10, column in 9:0 |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables: bit 0 lower byte, bit 1 upper byte |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_ucas_n | output | 1 | Upper-byte column strobe, active low |
| dram_lcas_n | output | 1 | Lower-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq | inout | 16 | Bidirectional data bus |

## Verification
The bench targets the following corner cases:
- Same-row requests issued back to back, to test the page-mode path. A controller that missed page hits would show extra row activations.
- Row and column halves checked on the bus against the host address. A swapped address mux would still read back correctly through a memory, so the bus check is what catches it.
- Single-lane writes followed by word reads, and single-lane reads, to test lane masking. A swapped or ignored strobe corrupts the other byte or returns bus noise.
- Long streams of back-to-back traffic, to check that refresh still arrives on time. A controller that let host requests starve refresh would stretch the gap between refreshes beyond the interval.
- The DRAM model times the strobes and flags any refresh with WE low. Too short a precharge, cycle or access window is reported.

// File: rtl/dram_page_ctrl.sv
`timescale 1ns/1ps
module dram_page_ctrl #(
  parameter int CLK_PS    = 10000,
  parameter int T_RAC_NS  = 50,
  parameter int T_CAC_NS  = 13,
  parameter int T_AA_NS   = 25,
  parameter int T_RC_NS   = 90,
  parameter int T_PC_NS   = 35,
  parameter int T_RP_NS   = 30,
  parameter int T_RAS_NS  = 50,
  parameter int T_CSR_NS  = 10,
  parameter int T_REF_NS  = 15600,
  parameter int T_INIT_NS = 200000,
  parameter int BOOT_REFS = 8,
  parameter int PEND_MAX  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [19:0] req_addr,
  input  logic [15:0] req_wdata,
  input  logic [1:0]  req_be,
  output logic        rsp_valid,
  output logic [15:0] rsp_rdata,
  output logic [9:0]  dram_addr,
  output logic        dram_ras_n,
  output logic        dram_ucas_n,
  output logic        dram_lcas_n,
  output logic        dram_we_n,
  output logic        dram_oe_n,
  inout  wire  [15:0] dram_dq
);
  function automatic int cdiv(input int ns);
    return (ns * 1000 + CLK_PS - 1) / CLK_PS;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int C_CAS  = imax(1, cdiv(imax(T_CAC_NS, T_AA_NS)));
  localparam int C_RCD  = imax(2, cdiv(T_RAC_NS) - C_CAS);
  localparam int C_CP   = imax(1, cdiv(T_PC_NS) - C_CAS - 1);
  localparam int C_RP   = imax(imax(1, cdiv(T_RP_NS)), cdiv(T_RC_NS) - (C_RCD + C_CAS + C_CP + 1));
  localparam int C_CSR  = imax(1, cdiv(T_CSR_NS));
  localparam int C_RASW = imax(imax(1, cdiv(T_RAS_NS)), cdiv(T_RC_NS) - C_RP - C_CSR);
  localparam int C_INIT = imax(1, cdiv(T_INIT_NS));
  localparam int C_REF  = imax(16, cdiv(T_REF_NS));
  localparam int CW = $clog2(imax(C_INIT, 64) + 1);
  localparam int RW = $clog2(C_REF + 1);
  localparam int PW = $clog2(PEND_MAX + 1);
  localparam int BW = $clog2(BOOT_REFS + 1);

  typedef enum logic [3:0] {
    S_INIT, S_IDLE, S_RSET, S_ROW, S_COL, S_CPRE, S_CSET, S_PRE, S_RFC, S_RFR, S_RFP
  } st_t;

  st_t           state, nstate;
  logic [CW-1:0] cnt;
  logic [BW-1:0] boot_left;
  logic [PW-1:0] pend;
  logic [RW-1:0] ref_tmr;
  logic [9:0]    row_q, col_q;
  logic [1:0]    be_q;
  logic          wr_q;
  logic [15:0]   wd_q;

  function automatic logic [CW-1:0] dur(input st_t s);
    case (s)
      S_INIT:        return CW'(C_INIT - 1);
      S_ROW:         return CW'(C_RCD - 1);
      S_COL:         return CW'(C_CAS - 1);
      S_CPRE:        return CW'(C_CP - 1);
      S_PRE, S_RFP:  return CW'(C_RP - 1);
      S_RFC:         return CW'(C_CSR - 1);
      S_RFR:         return CW'(C_RASW - 1);
      default:       return '0;
    endcase
  endfunction

  wire done     = (cnt == '0);
  wire booted   = (state != S_INIT) && (boot_left == '0);
  wire ref_due  = (boot_left != '0) || (pend != '0);
  wire page_hit = (req_addr[19:10] == row_q);
  assign req_ready = booted && (pend == '0) &&
                     ((state == S_IDLE) || (state == S_CPRE && done && page_hit));
  wire take     = req_valid && req_ready;
  wire tick     = booted && (ref_tmr == '0);
  wire ref_fin  = (state == S_RFP) && done;
  wire sample   = (state == S_COL) && done && !wr_q;

  always_comb begin
    nstate = state;
    case (state)
      S_INIT: if (done) nstate = S_IDLE;
      S_IDLE: if (ref_due) nstate = S_RFC; else if (take) nstate = S_RSET;
      S_RSET: nstate = S_ROW;
      S_ROW:  if (done) nstate = S_COL;
      S_COL:  if (done) nstate = S_CPRE;
      S_CPRE: if (done) nstate = take ? S_CSET : S_PRE;
      S_CSET: nstate = S_COL;
      S_PRE:  if (done) nstate = S_IDLE;
      S_RFC:  if (done) nstate = S_RFR;
      S_RFR:  if (done) nstate = S_RFP;
      S_RFP:  if (done) nstate = S_IDLE;
      default: nstate = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_INIT;
      cnt       <= CW'(C_INIT - 1);
      boot_left <= BW'(BOOT_REFS);
      pend      <= '0;
      ref_tmr   <= RW'(C_REF - 1);
      row_q     <= '0;
      col_q     <= '0;
      be_q      <= '0;
      wr_q      <= 1'b0;
      wd_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      state <= nstate;
      if (nstate != state) cnt <= dur(nstate);
      else if (!done)      cnt <= cnt - 1'b1;
      if (take) begin
        row_q <= req_addr[19:10];
        col_q <= req_addr[9:0];
        be_q  <= req_be;
        wr_q  <= req_write;
        wd_q  <= req_wdata;
      end
      if (booted) ref_tmr <= (ref_tmr == '0) ? RW'(C_REF - 1) : ref_tmr - 1'b1;
      if (ref_fin && boot_left != '0) boot_left <= boot_left - 1'b1;
      case ({tick && pend != PW'(PEND_MAX), ref_fin && boot_left == '0})
        2'b10:   pend <= pend + 1'b1;
        2'b01:   pend <= pend - 1'b1;
        default: ;
      endcase
      rsp_valid <= sample;
      if (sample) rsp_rdata <= dram_dq & {{8{be_q[1]}}, {8{be_q[0]}}};
    end
  end

  wire ref_cas  = (state == S_RFC) || (state == S_RFR);
  wire drive_wr = wr_q && (state inside {S_RSET, S_ROW, S_CSET, S_COL});
  assign dram_ras_n  = !(state inside {S_ROW, S_COL, S_CPRE, S_CSET, S_RFR});
  assign dram_lcas_n = !(ref_cas || (state == S_COL && be_q[0]));
  assign dram_ucas_n = !(ref_cas || (state == S_COL && be_q[1]));
  assign dram_we_n   = !drive_wr;
  assign dram_oe_n   = !(!wr_q && state == S_COL);
  assign dram_addr   = (state == S_RSET || (state == S_ROW && !done)) ? row_q : col_q;
  assign dram_dq     = drive_wr ? wd_q : 16'hzzzz;

  assert_ready_after_boot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (boot_left == '0))
    else $error("ready before start-up refreshes");
  assert_we_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_lcas_n) && !dram_ras_n && !dram_we_n) |-> $past(!dram_we_n))
    else $error("WE not set up before column strobe");
  assert_no_bus_fight_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_oe_n |-> dram_we_n)
    else $error("bus driven while output enabled");
  assert_rsp_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid)
    else $error("response longer than one cycle");
  assert_cbr_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ras_n) && !dram_lcas_n) |-> (dram_we_n && dram_oe_n && !dram_ucas_n && $past(!dram_lcas_n)))
    else $error("bad refresh strobe order");
  assert_pend_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= PW'(PEND_MAX))
    else $error("pending refresh overflow");
  assert_precharge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> ($past(dram_ras_n) && $past(dram_ras_n, 2)))
    else $error("row precharge too short");
endmodule

// File: tb/test_dram_page_ctrl.sv
`timescale 1ns/1ps
module test_dram_page_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int REF_CYC    = 1560;
  localparam int INIT_NS    = 2000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [19:0] req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic [1:0]  req_be = 0;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [9:0] dram_addr;
  logic dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n;
  wire [15:0] dram_dq;

  dram_page_ctrl #(.T_INIT_NS(INIT_NS)) i_dram_page_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_ucas_n(dram_ucas_n), .dram_lcas_n(dram_lcas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq(dram_dq));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // DRAM model
  logic [15:0] mem [int];
  logic [15:0] rd_word = 0;
  logic [9:0] m_row = 0, m_col = 0;
  bit prev_ras = 1, prev_l = 1, prev_u = 1;
  time t_ras_fall = 0, t_ras_rise = 0, t_cas_fall = 0, first_ras = 0, last_ref = 0, max_gap = 0;
  int act_cnt = 0, ref_cnt = 0, tim_err = 0, cbr_err = 0, wr_err = 0;

  assign dram_dq[7:0]  = (!dram_ras_n && !dram_lcas_n && !dram_oe_n) ? rd_word[7:0]  : 8'hzz;
  assign dram_dq[15:8] = (!dram_ras_n && !dram_ucas_n && !dram_oe_n) ? rd_word[15:8] : 8'hzz;

  always @(dram_ras_n or dram_lcas_n or dram_ucas_n) begin
    bit lf, uf;
    int a;
    lf = prev_l && !dram_lcas_n;
    uf = prev_u && !dram_ucas_n;
    if (prev_ras && !dram_ras_n) begin
      if (first_ras == 0) first_ras = $time;
      else begin
        if ($time - t_ras_rise < 30) tim_err++;
        if ($time - t_ras_fall < 90) tim_err++;
      end
      t_ras_fall = $time;
      if (!dram_lcas_n || !dram_ucas_n) begin
        ref_cnt++;
        if (!dram_we_n || !dram_oe_n || dram_lcas_n || dram_ucas_n) cbr_err++;
        if (last_ref != 0 && $time - last_ref > max_gap) max_gap = $time - last_ref;
        last_ref = $time;
      end else begin
        act_cnt++;
        m_row = dram_addr;
      end
    end
    if (!prev_ras && dram_ras_n) t_ras_rise = $time;
    if ((lf || uf) && !dram_ras_n) begin
      m_col = dram_addr;
      t_cas_fall = $time;
      if ($time - t_ras_fall < 20) tim_err++;
      a = {12'd0, m_row, m_col};
      if (!mem.exists(a)) mem[a] = 16'h0000;
      if (!dram_we_n) begin
        if (lf) begin
          if ($isunknown(dram_dq[7:0])) wr_err++;
          mem[a][7:0] = dram_dq[7:0];
        end
        if (uf) begin
          if ($isunknown(dram_dq[15:8])) wr_err++;
          mem[a][15:8] = dram_dq[15:8];
        end
      end
      rd_word = mem[a];
    end
    prev_ras = dram_ras_n;
    prev_l = dram_lcas_n;
    prev_u = dram_ucas_n;
  end

  // scoreboard
  logic [15:0] shadow [int];
  logic [15:0] exp_q [$];
  int reads_issued = 0, rsp_seen = 0;

  task automatic issue(input bit w, input logic [19:0] a, input logic [15:0] d, input logic [1:0] be);
    logic [15:0] m;
    m = {{8{be[1]}}, {8{be[0]}}};
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    if (!shadow.exists(int'(a))) shadow[int'(a)] = 16'h0000;
    if (w) shadow[int'(a)] = (shadow[int'(a)] & ~m) | (d & m);
    else begin
      exp_q.push_back(shadow[int'(a)] & m);
      reads_issued++;
    end
  endtask

  task automatic idle_drain();
    @(negedge clk);
    req_valid = 0;
    repeat (40) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      time smp;
      smp = $time - CLK_PERIOD/2;
      rsp_seen++;
      if (smp - t_ras_fall < 50 || smp - t_cas_fall < 13) tim_err++;
      if (exp_q.size() == 0) check(0, "R5", "unexpected response", rsp_rdata, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(rsp_rdata === e, "R5", "read data", rsp_rdata, e);
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    check(0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    time t_rel;
    int a0, r0, cyc;
    logic [19:0] lf;
    repeat (5) @(negedge clk);
    check(!req_ready && dram_ras_n && dram_lcas_n && dram_ucas_n && dram_we_n && dram_oe_n,
          "R1", "reset outputs", {req_ready, dram_ras_n, dram_lcas_n, dram_ucas_n}, 4'b0111);
    check(dram_dq === 16'hzzzz, "R4", "bus released in reset", dram_dq, 0);
    rst_n = 1;
    t_rel = $time;
    cyc = 0;
    while (!req_ready && cyc < 5000) begin @(negedge clk); cyc++; end
    check(ref_cnt == 8, "R1", "start-up refreshes", ref_cnt, 8);
    check(act_cnt == 0, "R1", "no access before ready", act_cnt, 0);
    check(first_ras - t_rel >= INIT_NS, "R1", "initial pause", int'(first_ras - t_rel), INIT_NS);
    check(cbr_err == 0, "R6", "refresh strobe errors", cbr_err, 0);

    // R8: page mode on one row
    a0 = act_cnt;
    issue(1, 20'h12345, 16'hA5C3, 2'b11);
    issue(1, 20'h12346, 16'h5A3C, 2'b11);
    issue(0, 20'h12345, 0, 2'b11);
    issue(0, 20'h12346, 0, 2'b11);
    idle_drain();
    check(act_cnt - a0 == 1, "R8", "row activations in page burst", act_cnt - a0, 1);

    // R2: address split
    issue(1, 20'hABCDE, 16'h0F0F, 2'b11);
    idle_drain();
    check(m_row == 10'h2AF, "R2", "row address", m_row, 10'h2AF);
    check(m_col == 10'h0DE, "R2", "column address", m_col, 10'h0DE);

    // R9: row changes
    a0 = act_cnt;
    issue(1, 20'h00401, 16'h1111, 2'b11);
    issue(1, 20'h00801, 16'h2222, 2'b11);
    issue(0, 20'h00401, 0, 2'b11);
    idle_drain();
    check(act_cnt - a0 == 3, "R9", "row activations across rows", act_cnt - a0, 3);

    // R3 / R5: byte lanes
    issue(1, 20'h55555, 16'h1234, 2'b11);
    issue(1, 20'h55555, 16'hFFAB, 2'b01);
    issue(1, 20'h55556, 16'hCDEE, 2'b10);
    issue(0, 20'h55555, 0, 2'b11);
    issue(0, 20'h55556, 0, 2'b11);
    issue(0, 20'h55555, 0, 2'b01);
    issue(0, 20'h55555, 0, 2'b10);
    idle_drain();
    check(mem[{12'd0, 10'h155, 10'h155}] == 16'h12AB, "R3", "lower-lane write", mem[{12'd0, 10'h155, 10'h155}], 16'h12AB);

    // R7: periodic refresh when idle
    r0 = ref_cnt;
    repeat (5 * REF_CYC) @(negedge clk);
    check(ref_cnt - r0 >= 4 && ref_cnt - r0 <= 6, "R7", "idle refresh count", ref_cnt - r0, 5);

    // R7: refresh under continuous traffic
    lf = 20'h1ACE1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[18:0], lf[19] ^ lf[16]};
      issue(i[0], (i % 3 == 0) ? {lf[19:10], lf[9:0] ^ 10'h3} : lf, lf[15:0] ^ 16'h9C6D, (i % 5 == 0) ? 2'b01 : 2'b11);
    end
    idle_drain();
    check(max_gap <= (REF_CYC + 40) * CLK_PERIOD, "R7", "max refresh gap ns", int'(max_gap), (REF_CYC + 40) * CLK_PERIOD);

    check(tim_err == 0, "R10", "strobe timing violations", tim_err, 0);
    check(wr_err == 0, "R4", "undriven write data", wr_err, 0);
    check(cbr_err == 0, "R6", "refresh strobe errors", cbr_err, 0);
    check(rsp_seen == reads_issued && exp_q.size() == 0, "R5", "responses", rsp_seen, reads_issued);
    finish_run();
  end
endmodule